// File: doc/BRIEF.md
# Reversal-Based Barrel Shifter

This block shifts or rotates one data word by a variable amount in a single combinational pass. It supports six operations: logical and arithmetic shifts and rotates, each in both directions. All six share one right-rotating network. For a left-direction operation, the block mirrors the operand's bit order before the network and mirrors the result again afterwards.

A keep-mask derived from the shift amount decides which rotated bits survive. The positions the mask drops are filled with zeros or with the sign bit. The same mask feeds a separate flag unit, which works from the operand and the shift amount directly. That unit produces an overflow flag for left shifts and a zero-result flag while the rotation is still settling, so neither flag waits on the shifted word.

The block is purely combinational and has no clock or reset. A surrounding pipeline registers its outputs wherever it needs to.

Top module: `rev_barrel_shifter`

## Requirements
- R1: With `op_i` = 3'b000 (logical right), `result_o` equals the operand shifted right by `shift_amt_i`, with zeros entering at the top.
- R2: With `op_i` = 3'b001 (arithmetic right), `result_o` equals the operand shifted right, with copies of operand bit WIDTH-1 entering at the top.
- R3: With `op_i` = 3'b010 (rotate right), bits leaving the bottom re-enter at the top, so no bit value is lost.
- R4: With `op_i` = 3'b100 (logical left), `result_o` equals the operand shifted left, with zeros entering at the bottom.
- R5: With `op_i` = 3'b101 (arithmetic left), `result_o` equals the operand shifted left, with zeros entering at the bottom.
- R6: With `op_i` = 3'b110 (rotate left), bits leaving the top re-enter at the bottom.
- R7: With `op_i` = 3'b011 or 3'b111 (unassigned codes), `result_o` equals the operand and `overflow_o` is 0.
- R8: When `shift_amt_i` is 0, `result_o` equals the operand for every opcode and `overflow_o` is 0.
- R9: For logical left, `overflow_o` is 1 exactly when at least one bit shifted out of the top is 1.
- R10: For arithmetic left, `overflow_o` is 1 exactly when a shifted-out bit or the new bit WIDTH-1 differs from the original bit WIDTH-1.
- R11: For right shifts and both rotates, `overflow_o` is 0.
- R12: `zero_o` is 1 exactly when every bit of `result_o` is 0. The flag is computed from the operand and the keep-mask, not from `result_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | WIDTH | Data word to shift or rotate |
| shift_amt_i | input | $clog2(WIDTH) | Shift or rotate distance, 0 to WIDTH-1 |
| op_i | input | 3 | Operation code: bit 2 selects left, bits 1:0 select logical/arithmetic/rotate |
| result_o | output | WIDTH | Shifted or rotated word |
| overflow_o | output | 1 | Left-shift overflow indication |
| zero_o | output | 1 | Result-is-zero indication |

## Verification
Every output is a combinational function of the current inputs, so each result, overflow and zero value is due in the same cycle as the stimulus, with no register delay. The bench applies each stimulus just after a falling clock edge and lets the logic settle for one nanosecond. It then samples all three outputs and compares them with a behavioural model, well before the next rising edge. Each opcode is exercised at every shift amount, from 0 through WIDTH-1, with random operands, together with directed overflow boundaries and all-zero and all-one operands.

// File: rtl/rbs_pkg.sv
`timescale 1ns/1ps
package rbs_pkg;
    // bit 2: direction (1 = left); bits 1:0: 00 logical, 01 arithmetic, 10 rotate
    typedef enum logic [2:0] {
        SHR_LOG = 3'b000,
        SHR_ARI = 3'b001,
        ROT_R   = 3'b010,
        SHL_LOG = 3'b100,
        SHL_ARI = 3'b101,
        ROT_L   = 3'b110
    } shop_e;
endpackage

// File: rtl/bit_mirror.sv
`timescale 1ns/1ps
module bit_mirror #(
    parameter int N = 32
) (
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    for (genvar i = 0; i < N; i++) begin : g_flip
        assign dout[i] = din[N-1-i];
    end
endmodule

// File: rtl/rotr_core.sv
`timescale 1ns/1ps
module rotr_core #(
    parameter  int N  = 32,
    localparam int AW = $clog2(N)
) (
    input  logic [N-1:0]  din,
    input  logic [AW-1:0] amt,
    output logic [N-1:0]  dout
);
    logic [N-1:0] stage [0:AW];

    assign stage[0] = din;

    // one stage per amount bit, each rotating by a power of two
    for (genvar k = 0; k < AW; k++) begin : g_stage
        localparam int R = 1 << k;
        assign stage[k+1] = amt[k] ? {stage[k][R-1:0], stage[k][N-1:R]} : stage[k];
    end

    assign dout = stage[AW];

    always_comb begin : rot_guard
        // R3
        rot_popcount_chk: assert ($countones(dout) == $countones(din))
            else $error("rotator changed the number of set bits");
    end
endmodule

// File: rtl/keep_mask_gen.sv
`timescale 1ns/1ps
module keep_mask_gen #(
    parameter  int N  = 32,
    localparam int AW = $clog2(N)
) (
    input  logic [AW-1:0] amt,
    output logic [N-1:0]  keep
);
    // a set bit marks a rotated position that holds real data after a right shift
    always_comb begin
        for (int i = 0; i < N; i++) begin
            keep[i] = (i <= (N - 1 - int'(amt)));
        end
    end
endmodule

// File: rtl/shift_flag_unit.sv
`timescale 1ns/1ps
module shift_flag_unit
    import rbs_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-1:0] operand,
    input  logic [N-1:0] keep,
    input  logic [2:0]   op,
    output logic         ovf,
    output logic         zero
);
    logic [N-1:0] keep_hi;     // operand bits surviving a right shift
    logic [N-1:0] sign_win;    // top s+1 operand bits for arithmetic left
    logic [N-1:0] sign_diff;
    logic         sign;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            keep_hi[i] = keep[N-1-i];
        end
        sign      = operand[N-1];
        sign_win  = ~(keep >> 1);
        sign_diff = operand ^ {N{sign}};
    end

    always_comb begin
        ovf  = 1'b0;
        zero = 1'b0;
        unique case (op)
            SHR_LOG, SHR_ARI: zero = ~|(operand & keep_hi);
            SHL_LOG: begin
                zero = ~|(operand & keep);
                ovf  = |(operand & ~keep);
            end
            SHL_ARI: begin
                zero = ~|(operand & keep);
                ovf  = |(sign_diff & sign_win);
            end
            default: zero = ~|operand;   // rotates and unassigned codes
        endcase
    end
endmodule

// File: rtl/rev_barrel_shifter.sv
`timescale 1ns/1ps
module rev_barrel_shifter
    import rbs_pkg::*;
#(
    parameter  int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] operand_i,
    input  logic [AMT_W-1:0] shift_amt_i,
    input  logic [2:0]       op_i,
    output logic [WIDTH-1:0] result_o,
    output logic             overflow_o,
    output logic             zero_o
);
    logic             is_left;
    logic             is_rot;
    logic             is_valid;
    logic             fill_bit;
    logic [WIDTH-1:0] mirrored_in;
    logic [WIDTH-1:0] core_in;
    logic [WIDTH-1:0] rotated;
    logic [WIDTH-1:0] keep;
    logic [WIDTH-1:0] shaped;
    logic [WIDTH-1:0] mirrored_out;
    logic [WIDTH-1:0] shifted;

    always_comb begin
        is_left  = op_i[2];
        is_rot   = (op_i[1:0] == 2'b10);
        is_valid = (op_i[1:0] != 2'b11);
        fill_bit = (op_i == SHR_ARI) & operand_i[WIDTH-1];
    end

    bit_mirror #(.N(WIDTH)) u_mirror_in (
        .din  (operand_i),
        .dout (mirrored_in)
    );

    assign core_in = is_left ? mirrored_in : operand_i;

    rotr_core #(.N(WIDTH)) u_core (
        .din  (core_in),
        .amt  (shift_amt_i),
        .dout (rotated)
    );

    keep_mask_gen #(.N(WIDTH)) u_mask (
        .amt  (shift_amt_i),
        .keep (keep)
    );

    always_comb begin
        if (is_rot) shaped = rotated;
        else        shaped = (rotated & keep) | (~keep & {WIDTH{fill_bit}});
    end

    bit_mirror #(.N(WIDTH)) u_mirror_out (
        .din  (shaped),
        .dout (mirrored_out)
    );

    always_comb begin
        shifted  = is_left ? mirrored_out : shaped;
        result_o = is_valid ? shifted : operand_i;
    end

    shift_flag_unit #(.N(WIDTH)) u_flags (
        .operand (operand_i),
        .keep    (keep),
        .op      (op_i),
        .ovf     (overflow_o),
        .zero    (zero_o)
    );

    always_comb begin : top_guard
        // R12
        zero_flag_chk: assert (zero_o == (result_o == '0))
            else $error("zero flag disagrees with result");
        // R8
        zero_amt_chk: assert (!(shift_amt_i == '0) || (result_o == operand_i && !overflow_o))
            else $error("zero shift altered the word");
        // R7
        pass_through_chk: assert (is_valid || (result_o == operand_i && !overflow_o))
            else $error("unassigned code altered the word");
        // R11
        no_overflow_chk: assert (is_left && !is_rot || !overflow_o)
            else $error("overflow raised outside left shifts");
    end
endmodule

// File: tb/rev_barrel_shifter_test.sv
`timescale 1ns/1ps
module rev_barrel_shifter_test;
    localparam int W  = 32;
    localparam int AW = $clog2(W);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  operand;
    logic [AW-1:0] amt;
    logic [2:0]    op;
    logic [W-1:0]  result;
    logic          overflow;
    logic          zero;
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    always #2.5 clk = ~clk;

    rev_barrel_shifter #(.WIDTH(W)) uut (
        .operand_i   (operand),
        .shift_amt_i (amt),
        .op_i        (op),
        .result_o    (result),
        .overflow_o  (overflow),
        .zero_o      (zero)
    );

    function automatic string op_tag(input logic [2:0] o);
        case (o)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010:  return "R3";
            3'b100:  return "R4";
            3'b101:  return "R5";
            3'b110:  return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic string ovf_tag(input logic [2:0] o);
        case (o)
            3'b100:  return "R9";
            3'b101:  return "R10";
            3'b000, 3'b001, 3'b010, 3'b110: return "R11";
            default: return "R7";
        endcase
    endfunction

    task automatic model(input logic [W-1:0] a, input int s, input logic [2:0] o,
                         output logic [W-1:0] r, output logic ov);
        ov = 1'b0;
        case (o)
            3'b000: r = a >> s;
            3'b001: r = $unsigned($signed(a) >>> s);
            3'b010: r = (s == 0) ? a : ((a >> s) | (a << (W - s)));
            3'b100, 3'b101: r = a << s;
            3'b110: r = (s == 0) ? a : ((a << s) | (a >> (W - s)));
            default: r = a;
        endcase
        if (o == 3'b100)
            for (int i = W - s; i < W; i++) if (a[i]) ov = 1'b1;
        if (o == 3'b101)
            for (int i = W - 1 - s; i < W; i++) if (a[i] != a[W-1]) ov = 1'b1;
    endtask

    task automatic check(input string req, input string what,
                         input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h (op=%b amt=%0d a=%h)",
                     req, what, got, exp, op, amt, operand);
        end
    endtask

    // drive after a falling edge; outputs are combinational, sample 1 ns later
    task automatic apply(input logic [W-1:0] a, input int s, input logic [2:0] o);
        logic [W-1:0] er;
        logic         eo;
        @(negedge clk);
        operand = a;
        amt     = s[AW-1:0];
        op      = o;
        #1;
        model(a, s, o, er, eo);
        check(s == 0 ? "R8" : op_tag(o), "result", result, er);
        check(s == 0 && eo == 1'b0 ? "R8" : ovf_tag(o), "overflow", {31'b0, overflow}, {31'b0, eo});
        check("R12", "zero", {31'b0, zero}, {31'b0, (er == '0)});
    endtask

    task automatic test_initial_state();
        apply('0, 0, 3'b000);
    endtask

    task automatic test_all_ops_all_amounts();
        logic [2:0] ops [6] = '{3'b000, 3'b001, 3'b010, 3'b100, 3'b101, 3'b110};
        for (int k = 0; k < 6; k++)
            for (int s = 0; s < W; s++)
                for (int n = 0; n < 4; n++)
                    apply($urandom, s, ops[k]);
    endtask

    task automatic test_unassigned_codes();   // R7
        for (int s = 0; s < W; s += 5) begin
            apply($urandom, s, 3'b011);
            apply($urandom, s, 3'b111);
        end
        apply('0, 7, 3'b111);
    endtask

    task automatic test_overflow_edges();     // R9, R10
        apply(32'h8000_0000, 1, 3'b100);
        apply(32'h0000_0001, 31, 3'b100);
        apply(32'h0000_0003, 31, 3'b100);
        apply(32'h4000_0000, 1, 3'b101);
        apply(32'hFFFF_FFFF, 31, 3'b101);
        apply(32'hC000_0000, 1, 3'b101);
        apply(32'hC000_0000, 2, 3'b101);
        apply(32'h8000_0000, 0, 3'b101);
    endtask

    task automatic test_zero_flag();          // R12
        apply(32'h0000_FFFF, 16, 3'b000);
        apply(32'h8000_0000, 31, 3'b001);
        apply(32'hFFFF_0000, 16, 3'b100);
        apply(32'h0000_0001, 31, 3'b010);
        apply('0, 13, 3'b110);
        apply(32'hFFFF_FFFF, 31, 3'b000);
    endtask

    initial begin
        operand = '0;
        amt     = '0;
        op      = '0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        test_initial_state();
        test_all_ops_all_amounts();
        test_unassigned_codes();
        test_overflow_edges();
        test_zero_flag();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule